// File: doc/BRIEF.md
# Prefetch Address Break Unit

This unit watches the instruction-prefetch side of a CPU and raises an interrupt request when a prefetch lands on a break address that software has programmed. It compares only cycles that carry the prefetch strobe, so data reads and writes to the same location never trigger it. The lowest address bit takes no part in the comparison, because a break is meant to sit on the first byte of an instruction. The request is marked as unmaskable, which means the CPU's ordinary interrupt mask bits cannot hold it off. Priority resolution and exception entry are left to the interrupt controller and the CPU.

Software reaches two registers through a small synchronous port. The break address register holds every address bit except bit 0. The control/status register holds an enable bit and a sticky hit flag. The flag can only be cleared by first reading it as 1 and then writing a 0 to it. A new hit in the same cycle as the clear wins, and the flag stays set. The unit does not filter out prefetches that a branch, jump, call or return just ahead of the break address issues for that address. Software has to tell those apart from real hits in its handler.

Top module: `pab_unit`

## Requirements
- R1: After reset, both registers read 0, the function is disabled, and `brk_irq` and `brk_unmask` are 0.
- R2: The break address register (`reg_sel`=0) stores bits ADDR_W-1..1 and reads bit 0 back as 0. Address bit 0 is ignored in the comparison.
- R3: The hit flag sets on the clock edge that ends a cycle in which `pf_strobe` is 1, the enable bit is 1 and `pf_addr` equals the break address (bit 0 excluded). If `pf_strobe` is 0, nothing sets the flag.
- R4: While the enable bit (control register bit 0) is 0, a matching prefetch leaves the flag (control register bit 1) at 0.
- R5: `brk_irq` is 1 exactly when the enable bit and the flag are both 1. `brk_unmask` carries the same value, so the request is marked as immune to CPU masking.
- R6: A write of 0 to the flag that is not preceded by a read of the control register returning flag=1 leaves the flag set.
- R7: A read of the control register that returns flag=1, followed later by a write with flag bit 0, clears the flag on that write's edge.
- R8: A hit in the same cycle as a valid clear leaves the flag set.
- R9: Writing 1 to the flag bit never sets the flag. Only the enable bit takes the written value.
- R10: Clearing the enable bit drops `brk_irq` on that write's edge. The flag keeps its value.
- R11: Matching prefetches in back-to-back cycles keep the flag and `brk_irq` at 1 without a gap.
- R12: `reg_rdata` updates on the edge of a cycle with `reg_rd`=1 and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 break address, 1 control/status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Registered read data |
| pf_strobe | input | 1 | Instruction-prefetch cycle qualifier |
| pf_addr | input | ADDR_W | Prefetch address |
| brk_irq | output | 1 | Break interrupt request level |
| brk_unmask | output | 1 | Marks the request as not subject to CPU masking |

## Verification
A wrong comparator or a wrong enable state shows on `brk_irq` at the first sample after the prefetch edge, because the flag and the request share one register stage. A wrong state in the clear handshake stays hidden until software attempts a clear. It then shows at the next control read as a flag that either survived or vanished. Stale read data shows one cycle after the read strobe, or during idle cycles as a value that changes when it should hold.

// File: rtl/pab_pkg.sv
package pab_pkg;
   typedef enum logic {
      SEL_BRKADR = 1'b0,
      SEL_CTRL   = 1'b1
   } pab_sel_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/pab_cmp.sv
module pab_cmp #(
   parameter int ADDR_W     = 24,
   parameter bit IGNORE_LSB = 1'b1
) (
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] brk_addr_i,
   output logic              hit_o
);
   logic [ADDR_W-1:0] eq_bits;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (IGNORE_LSB && i == 0) begin : g_skip
         assign eq_bits[i] = 1'b1 | (addr_i[i] ^ brk_addr_i[i]);
      end else begin : g_cmp
         assign eq_bits[i] = ~(addr_i[i] ^ brk_addr_i[i]);
      end
   end

   assign hit_o = strobe_i & (&eq_bits);
endmodule

// File: rtl/pab_regs.sv
module pab_regs
   import pab_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter bit IGNORE_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pab_sel_e          sel_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] wdata_i,
   input  logic              flag_i,
   output logic [ADDR_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] brk_addr_o,
   output logic              en_o,
   output logic              arm_o,
   output logic              clr_o
);
   localparam int LO = IGNORE_LSB ? 1 : 0;

   logic              ctrl_wr;
   logic [ADDR_W-1:0] ctrl_view;
   logic [ADDR_W-1:0] rd_mux;

   assign ctrl_wr = wr_i && (sel_i == SEL_CTRL);

   if (IGNORE_LSB) begin : g_half
      logic [ADDR_W-1:1] addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             addr_q <= '0;
         else if (wr_i && sel_i == SEL_BRKADR)   addr_q <= wdata_i[ADDR_W-1:1];
      end
      assign brk_addr_o = {addr_q, 1'b0};
   end else begin : g_full
      logic [ADDR_W-1:0] addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             addr_q <= '0;
         else if (wr_i && sel_i == SEL_BRKADR)   addr_q <= wdata_i;
      end
      assign brk_addr_o = addr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_o <= 1'b0;
      else if (ctrl_wr) en_o <= wdata_i[CTRL_EN_BIT];
   end

   always_comb begin
      ctrl_view                = '0;
      ctrl_view[CTRL_EN_BIT]   = en_o;
      ctrl_view[CTRL_FLAG_BIT] = flag_i;
      rd_mux = (sel_i == SEL_CTRL) ? ctrl_view : brk_addr_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rd_mux;
   end

   assign arm_o = rd_i && (sel_i == SEL_CTRL) && flag_i;
   assign clr_o = ctrl_wr && !wdata_i[CTRL_FLAG_BIT];

   // R2
   lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && sel_i == SEL_BRKADR && LO == 1) |=> (rdata_o[0] == 1'b0));

   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/pab_flag.sv
module pab_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic arm_i,
   input  logic clr_i,
   output logic flag_o
);
   logic armed_q;
   logic flag_d;

   always_comb begin
      if (set_i)                 flag_d = 1'b1;
      else if (clr_i && armed_q) flag_d = 1'b0;
      else                       flag_d = flag_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         flag_o <= flag_d;
         if (!flag_d)    armed_q <= 1'b0;
         else if (arm_i) armed_q <= 1'b1;
      end
   end

   // R7
   clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(armed_q && clr_i));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
endmodule

// File: rtl/pab_unit.sv
module pab_unit
   import pab_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter bit IGNORE_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              pf_strobe,
   input  logic [ADDR_W-1:0] pf_addr,
   output logic              brk_irq,
   output logic              brk_unmask
);
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
      $error("pab_unit: ADDR_W must lie in 2..32");
   end

   pab_sel_e          sel;
   logic [ADDR_W-1:0] brk_addr;
   logic              en;
   logic              hit;
   logic              flag;
   logic              arm;
   logic              clr;

   assign sel = pab_sel_e'(reg_sel);

   pab_regs #(.ADDR_W(ADDR_W), .IGNORE_LSB(IGNORE_LSB)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_i(reg_wr), .rd_i(reg_rd),
      .wdata_i(reg_wdata), .flag_i(flag), .rdata_o(reg_rdata),
      .brk_addr_o(brk_addr), .en_o(en), .arm_o(arm), .clr_o(clr)
   );

   pab_cmp #(.ADDR_W(ADDR_W), .IGNORE_LSB(IGNORE_LSB)) u_cmp (
      .strobe_i(pf_strobe), .addr_i(pf_addr), .brk_addr_i(brk_addr), .hit_o(hit)
   );

   pab_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(hit && en), .arm_i(arm),
      .clr_i(clr), .flag_o(flag)
   );

   assign brk_irq    = en & flag;
   assign brk_unmask = brk_irq;

   // R3
   strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(pf_strobe));

   // R4
   disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !flag) |=> !flag);

   // R10
   en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> !brk_irq);
endmodule

// File: tb/tb_pab_unit.sv
module tb_pab_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam logic [AW-1:0] BRK = 24'h012344;
   localparam int NV = 8;
   // {strobe, addr, expected irq}
   localparam logic [25:0] VEC [NV] = '{
      {1'b0, 24'h012344, 1'b0},
      {1'b1, 24'h012344, 1'b1},
      {1'b1, 24'h012345, 1'b1},
      {1'b1, 24'h012346, 1'b0},
      {1'b1, 24'h112344, 1'b0},
      {1'b0, 24'h012345, 1'b0},
      {1'b1, 24'h000000, 1'b0},
      {1'b1, 24'h812344, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic          pf_strobe = 1'b0;
   logic [AW-1:0] pf_addr = '0;
   logic          brk_irq, brk_unmask;
   int            n_chk = 0, n_bad = 0;
   bit            done = 1'b0;
   logic [AW-1:0] rv, hold;

   always #(CLK_PERIOD/2) clk = ~clk;

   pab_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pf_strobe(pf_strobe), .pf_addr(pf_addr), .brk_irq(brk_irq),
      .brk_unmask(brk_unmask)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [AW-1:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [AW-1:0] d);
      reg_sel = sel; reg_rd = 1'b1;
      step();
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pf(input logic s, input logic [AW-1:0] a);
      pf_strobe = s; pf_addr = a;
      step();
      pf_strobe = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'b0, brk_irq}, 0);
      chk("R1 unmask", {31'b0, brk_unmask}, 0);
      rst_n = 1'b1;
      step();
      rd(1'b0, rv); chk("R1 brkadr", {8'b0, rv}, 0);
      rd(1'b1, rv); chk("R1 ctrl", {8'b0, rv}, 0);

      // R2 bit 0 not stored
      wr(1'b0, 24'hABCDEF);
      rd(1'b0, rv); chk("R2 readback", {8'b0, rv}, 32'hABCDEE);

      // R4 disabled: match does not set flag
      wr(1'b0, BRK);
      pf(1'b1, BRK);
      chk("R4 irq", {31'b0, brk_irq}, 0);
      rd(1'b1, rv); chk("R4 ctrl", {8'b0, rv}, 0);

      // R9 writing flag=1 does not set it
      wr(1'b1, 24'h3);
      rd(1'b1, rv); chk("R9 ctrl", {8'b0, rv}, 1);

      // R3 / R5 vector table
      for (int i = 0; i < NV; i++) begin
         pf(VEC[i][25], VEC[i][24:1]);
         chk("R3 irq", {31'b0, brk_irq}, {31'b0, VEC[i][0]});
         chk("R5 unmask", {31'b0, brk_unmask}, {31'b0, VEC[i][0]});
         if (VEC[i][0]) begin
            rd(1'b1, rv);
            wr(1'b1, 24'h1);
            chk("R7 cleared", {31'b0, brk_irq}, 0);
         end
      end

      // R6 clear without prior read is ignored; R7 then works
      pf(1'b1, BRK);
      wr(1'b1, 24'h1);
      chk("R6 irq kept", {31'b0, brk_irq}, 1);
      rd(1'b1, rv); chk("R6 ctrl", {8'b0, rv}, 3);
      wr(1'b1, 24'h1);
      rd(1'b1, rv); chk("R7 ctrl", {8'b0, rv}, 1);

      // R10 disable drops irq, flag kept
      pf(1'b1, BRK);
      wr(1'b1, 24'h0);
      chk("R10 irq", {31'b0, brk_irq}, 0);
      rd(1'b1, rv); chk("R10 ctrl", {8'b0, rv}, 2);
      wr(1'b1, 24'h1);
      rd(1'b1, rv); chk("R10 after clr", {8'b0, rv}, 1);

      // R8 hit simultaneous with valid clear
      pf(1'b1, BRK);
      rd(1'b1, rv);
      reg_sel = 1'b1; reg_wdata = 24'h1; reg_wr = 1'b1;
      pf_strobe = 1'b1; pf_addr = BRK;
      step();
      reg_wr = 1'b0; pf_strobe = 1'b0;
      rd(1'b1, rv); chk("R8 ctrl", {8'b0, rv}, 3);
      wr(1'b1, 24'h1);
      chk("R8 cleared after", {31'b0, brk_irq}, 0);

      // R11 back-to-back matches
      pf_strobe = 1'b1; pf_addr = BRK;
      step();
      chk("R11 first", {31'b0, brk_irq}, 1);
      pf_addr = BRK | 24'h1;
      step();
      chk("R11 second", {31'b0, brk_irq}, 1);
      pf_strobe = 1'b0;
      step();
      chk("R11 held", {31'b0, brk_irq}, 1);

      // R12 read data holds without read strobe
      rd(1'b0, rv);
      hold = reg_rdata;
      reg_sel = 1'b1;
      step(); step();
      chk("R12 hold", {8'b0, reg_rdata}, {8'b0, hold});
      chk("R12 value", {8'b0, hold}, {8'b0, BRK});

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule